// File: doc/BRIEF.md
# Dual-Width Integer Execution Unit

This unit is the integer arithmetic stage of a 64-bit register machine. Each accepted cycle it takes an 8-bit operation byte, the current destination register value, a source register value and a 32-bit immediate. One cycle later it returns the value to write back into the destination register, together with a valid strobe and an illegal-operation flag. It does not fetch instructions, does not hold the register file and raises no trap. The surrounding pipeline decides what to do when the flag is set.

The operation byte does three jobs. Its top nibble names the operation. Bit 3 chooses whether the second operand is the source register or the immediate. The low three bits choose between a 32-bit flavour and a 64-bit flavour of the same operation. In the 32-bit flavour both operands are cut to their low halves and the result is zero-extended back to 64 bits. In the 64-bit flavour the immediate is sign-extended before use.

Top module: `xalu_top`

## Requirements
- R1: `opcode[2:0]` selects the width: 3'h4 gives 32-bit operation and 3'h7 gives 64-bit operation. Any other value sets `illegal` and returns `dst_in` unchanged.
- R2: `opcode[3]`=1 takes `src_in` as the second operand. `opcode[3]`=0 takes `imm` instead, sign-extended to 64 bits in 64-bit mode and used as a plain 32-bit value in 32-bit mode.
- R3: In 32-bit mode both operands are truncated to bits [31:0]. The 32-bit result is zero-extended, so `result[63:32]` is 0 except when R7 or R9 returns the destination unchanged.
- R4: `opcode[7:4]` selects the operation. Add is 0x0, subtract 0x1, multiply 0x2 (low half kept), OR 0x4, AND 0x5, XOR 0xa, and move 0xb (result = second operand). All wrap modulo the operating width.
- R5: Left shift is 0x6, logical right shift 0x7 and arithmetic right shift 0xc. The shift count is the low 5 bits of the second operand in 32-bit mode and the low 6 bits in 64-bit mode.
- R6: Code 0x3 is unsigned division. A zero divisor gives a result of 0.
- R7: Code 0x9 is unsigned remainder. A zero divisor returns `dst_in` unchanged, all 64 bits.
- R8: Code 0x8 returns the two's-complement negation of the destination at the operating width. The second operand has no effect.
- R9: Codes 0xd, 0xe and 0xf set `illegal` and return `dst_in` unchanged. Every other code with a valid width clears `illegal`.
- R10: `out_valid` is `in_valid` delayed by one clock. `result` changes only in the cycle after an accepted input. `illegal` is low whenever `out_valid` is low.
- R11: While `rst_n` is low, `out_valid`, `illegal` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| opcode | input | 8 | Operation byte: code [7:4], source select [3], width class [2:0] |
| dst_in | input | 64 | Current destination register value (first operand) |
| src_in | input | 64 | Source register value |
| imm | input | 32 | Immediate operand |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 64 | New destination value |
| illegal | output | 1 | Unsupported operation or width class |

## Verification
The only state is the output stage, so any internal fault shows at `result` or `illegal` exactly one clock after the operation that caused it. No fault can stay hidden across later operations.

The bench sweeps all sixteen codes, both operand sources and both legal and illegal width classes over a set of operand vectors. These vectors hit the corners: zero divisors, shift counts at or above the 32-bit mask, negative immediates, and upper halves that must be discarded. A wrong decode, a wrong extension or a missing mask therefore appears in the very next result. A wrong hold or valid path appears in the idle cycle after a sweep.

// File: rtl/xalu_pkg.sv
package xalu_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'h0,
      OP_SUB  = 4'h1,
      OP_MUL  = 4'h2,
      OP_DIV  = 4'h3,
      OP_OR   = 4'h4,
      OP_AND  = 4'h5,
      OP_SHL  = 4'h6,
      OP_SHR  = 4'h7,
      OP_NEG  = 4'h8,
      OP_REM  = 4'h9,
      OP_XOR  = 4'ha,
      OP_MOVE = 4'hb,
      OP_SAR  = 4'hc,
      OP_SWAP = 4'hd,
      OP_RSVE = 4'he,
      OP_RSVF = 4'hf
   } alu_op_e;

   localparam logic [2:0] CLS_NARROW = 3'h4;
   localparam logic [2:0] CLS_WIDE   = 3'h7;

   typedef struct packed {
      alu_op_e op;
      logic    use_reg;
      logic    wide;
      logic    bad;
   } dec_t;

endpackage

// File: rtl/xalu_decode.sv
module xalu_decode
   import xalu_pkg::*;
(
   input  logic [7:0] opcode,
   output dec_t       dec
);

   logic cls_ok;
   logic op_ok;

   always_comb begin
      cls_ok      = (opcode[2:0] == CLS_NARROW) || (opcode[2:0] == CLS_WIDE);
      op_ok       = (opcode[7:4] < 4'hd);
      dec.op      = alu_op_e'(opcode[7:4]);
      dec.use_reg = opcode[3];
      dec.wide    = (opcode[2:0] == CLS_WIDE);
      dec.bad     = !(cls_ok && op_ok);
   end

endmodule

// File: rtl/xalu_opsel.sv
module xalu_opsel #(
   parameter int DATA_W = 64,
   parameter int IMM_W  = 32
) (
   input  logic              use_reg,
   input  logic              wide,
   input  logic [DATA_W-1:0] src_in,
   input  logic [IMM_W-1:0]  imm,
   output logic [DATA_W-1:0] b_op
);

   localparam int EXT_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] imm_s;
   logic [DATA_W-1:0] imm_z;

   generate
      if (EXT_W > 0) begin : g_ext
         assign imm_s = {{EXT_W{imm[IMM_W-1]}}, imm};
         assign imm_z = {{EXT_W{1'b0}}, imm};
      end else begin : g_noext
         assign imm_s = imm;
         assign imm_z = imm;
      end
   endgenerate

   always_comb begin
      if (use_reg)   b_op = src_in;
      else if (wide) b_op = imm_s;
      else           b_op = imm_z;
   end

endmodule

// File: rtl/xalu_lane.sv
module xalu_lane
   import xalu_pkg::*;
#(
   parameter int W = 32
) (
   input  alu_op_e      op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y,
   output logic         keep
);

   localparam int SHW = $clog2(W);

   logic [SHW-1:0] sh;
   logic           b_zero;

   assign sh     = b[SHW-1:0];
   assign b_zero = (b == '0);

   always_comb begin
      keep = 1'b0;
      y    = '0;
      unique case (op)
         OP_ADD:  y = a + b;
         OP_SUB:  y = a - b;
         OP_MUL:  y = a * b;
         OP_DIV:  y = b_zero ? '0 : a / b;
         OP_OR:   y = a | b;
         OP_AND:  y = a & b;
         OP_SHL:  y = a << sh;
         OP_SHR:  y = a >> sh;
         OP_NEG:  y = '0 - a;
         OP_REM: begin
            if (b_zero) begin
               keep = 1'b1;
               y    = a;
            end else begin
               y = a % b;
            end
         end
         OP_XOR:  y = a ^ b;
         OP_MOVE: y = b;
         OP_SAR:  y = $unsigned($signed(a) >>> sh);
         default: y = '0;
      endcase
   end

endmodule

// File: rtl/xalu_top.sv
module xalu_top
   import xalu_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int HALF_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        opcode,
   input  logic [DATA_W-1:0] dst_in,
   input  logic [DATA_W-1:0] src_in,
   input  logic [HALF_W-1:0] imm,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              illegal
);

   localparam int N_LANES = 2;

   generate
      if (DATA_W != 2 * HALF_W) begin : g_bad_width
         $error("xalu_top: DATA_W must be twice HALF_W");
      end
      if (HALF_W < 8) begin : g_bad_half
         $error("xalu_top: HALF_W too small");
      end
   endgenerate

   dec_t              dec;
   logic [DATA_W-1:0] b_op;
   logic [DATA_W-1:0] lane_y    [N_LANES];
   logic              lane_keep [N_LANES];
   logic [DATA_W-1:0] next_res;
   logic              sel;

   xalu_decode u_dec (
      .opcode (opcode),
      .dec    (dec)
   );

   xalu_opsel #(.DATA_W(DATA_W), .IMM_W(HALF_W)) u_opsel (
      .use_reg (dec.use_reg),
      .wide    (dec.wide),
      .src_in  (src_in),
      .imm     (imm),
      .b_op    (b_op)
   );

   generate
      for (genvar g = 0; g < N_LANES; g++) begin : g_lane
         localparam int LW = (g == 0) ? HALF_W : DATA_W;
         logic [LW-1:0] y_w;
         logic          k_w;
         xalu_lane #(.W(LW)) u_lane (
            .op   (dec.op),
            .a    (dst_in[LW-1:0]),
            .b    (b_op[LW-1:0]),
            .y    (y_w),
            .keep (k_w)
         );
         assign lane_y[g]    = DATA_W'(y_w);
         assign lane_keep[g] = k_w;
      end
   endgenerate

   assign sel = dec.wide;

   always_comb begin
      if (dec.bad || lane_keep[sel]) next_res = dst_in;
      else                           next_res = lane_y[sel];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         illegal   <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         illegal   <= in_valid && dec.bad;
         if (in_valid) result <= next_res;
      end
   end

endmodule

// File: rtl/xalu_chk.sv
module xalu_chk #(
   parameter int DATA_W = 64,
   parameter int HALF_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [7:0]        opcode,
   input logic              out_valid,
   input logic [DATA_W-1:0] result,
   input logic              illegal
);

   assert_valid_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_valid_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));

   assert_flag_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> out_valid);

   assert_bad_class_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode[2:0] != 3'h4 && opcode[2:0] != 3'h7) |=> illegal);

   assert_bad_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode[7:4] >= 4'hd) |=> illegal);

   assert_narrow_zext_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode[2:0] == 3'h4 && opcode[7:4] != 4'h9 && opcode[7:4] < 4'hd)
      |=> (result[DATA_W-1:HALF_W] == '0));

   assert_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid && !illegal && result == '0));

endmodule

bind xalu_top xalu_chk #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_chk (.*);

// File: tb/tb_xalu_top.sv
`timescale 1ns/1ps
module tb_xalu_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  opcode = 8'h0;
   logic [63:0] dst_in = '0;
   logic [63:0] src_in = '0;
   logic [31:0] imm = '0;
   logic        out_valid;
   logic [63:0] result;
   logic        illegal;

   int total = 0;
   int bad = 0;

   logic [63:0] vd [10];
   logic [63:0] vs [10];
   logic [31:0] vi [10];

   always #2 clk = ~clk;

   xalu_top dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
      .dst_in(dst_in), .src_in(src_in), .imm(imm),
      .out_valid(out_valid), .result(result), .illegal(illegal)
   );

   // returns {illegal, result}
   function automatic logic [64:0] model(input logic [7:0] op8, input logic [63:0] d,
                                         input logic [63:0] s, input logic [31:0] i);
      logic [3:0]  code;
      logic [63:0] b;
      logic [31:0] a32, b32, r32;
      logic [63:0] r64;
      code = op8[7:4];
      if (op8[2:0] != 3'h4 && op8[2:0] != 3'h7) return {1'b1, d};
      if (code >= 4'hd) return {1'b1, d};
      if (op8[3]) b = s;
      else if (op8[2:0] == 3'h7) b = {{32{i[31]}}, i};
      else b = {32'h0, i};
      if (op8[2:0] == 3'h4) begin
         a32 = d[31:0];
         b32 = b[31:0];
         case (code)
            4'h0: r32 = a32 + b32;
            4'h1: r32 = a32 - b32;
            4'h2: r32 = a32 * b32;
            4'h3: r32 = (b32 == 0) ? 32'h0 : a32 / b32;
            4'h4: r32 = a32 | b32;
            4'h5: r32 = a32 & b32;
            4'h6: r32 = a32 << b32[4:0];
            4'h7: r32 = a32 >> b32[4:0];
            4'h8: r32 = ~a32 + 32'h1;
            4'h9: begin
               if (b32 == 0) return {1'b0, d};
               r32 = a32 % b32;
            end
            4'ha: r32 = a32 ^ b32;
            4'hb: r32 = b32;
            default: r32 = $unsigned($signed(a32) >>> b32[4:0]);
         endcase
         return {1'b0, 32'h0, r32};
      end
      case (code)
         4'h0: r64 = d + b;
         4'h1: r64 = d - b;
         4'h2: r64 = d * b;
         4'h3: r64 = (b == 0) ? 64'h0 : d / b;
         4'h4: r64 = d | b;
         4'h5: r64 = d & b;
         4'h6: r64 = d << b[5:0];
         4'h7: r64 = d >> b[5:0];
         4'h8: r64 = ~d + 64'h1;
         4'h9: begin
            if (b == 0) return {1'b0, d};
            r64 = d % b;
         end
         4'ha: r64 = d ^ b;
         4'hb: r64 = b;
         default: r64 = $unsigned($signed(d) >>> b[5:0]);
      endcase
      return {1'b0, r64};
   endfunction

   function automatic string tag_of(input logic [7:0] op8);
      if (op8[2:0] != 3'h4 && op8[2:0] != 3'h7) return "R1";
      case (op8[7:4])
         4'h3: return "R6";
         4'h9: return "R7";
         4'h8: return "R8";
         4'h6, 4'h7, 4'hc: return "R5";
         4'hd, 4'he, 4'hf: return "R9";
         default: return (op8[2:0] == 3'h4) ? "R3" : "R4";
      endcase
   endfunction

   task automatic check(input string tag, input logic [65:0] got, input logic [65:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s actual v/ill/res=%h expected=%h", tag, got, exp);
      end
   endtask

   // called at a negedge; leaves at the negedge after the capturing posedge
   task automatic issue(input string tag, input logic [7:0] op8, input logic [63:0] d,
                        input logic [63:0] s, input logic [31:0] i);
      logic [64:0] e;
      in_valid = 1'b1; opcode = op8; dst_in = d; src_in = s; imm = i;
      e = model(op8, d, s, i);
      @(negedge clk);
      check(tag, {out_valid, illegal, result}, {1'b1, e});
   endtask

   task automatic idle_gap();
      logic [63:0] held;
      held = result;
      in_valid = 1'b0; opcode = 8'hd7; dst_in = ~dst_in; src_in = ~src_in; imm = ~imm;
      @(negedge clk);
      check("R10", {out_valid, illegal, result}, {2'b00, held});
   endtask

   initial begin
      #(4 * 200000);
      bad++;
      total++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      vd[0] = 64'h0000000500000007; vs[0] = 64'h0000000300000002; vi[0] = 32'h3;
      vd[1] = 64'hFFFFFFFFFFFFFFFF; vs[1] = 64'h1;                vi[1] = 32'hFFFFFFFF;
      vd[2] = 64'h123456789ABCDEF0; vs[2] = 64'h0;                vi[2] = 32'h0;
      vd[3] = 64'h8000000080000000; vs[3] = 64'h3F;               vi[3] = 32'h24;
      vd[4] = 64'hDEADBEEFCAFEF00D; vs[4] = 64'hFFFFFFFF00000021; vi[4] = 32'h80000005;
      vd[5] = 64'h7;                vs[5] = 64'hFFFFFFFFFFFFFFFE; vi[5] = 32'hFFFFFFF9;
      vd[6] = 64'h0000000100000000; vs[6] = 64'h0000000100000000; vi[6] = 32'h7FFFFFFF;
      vd[7] = 64'h7FFFFFFFFFFFFFFF; vs[7] = 64'h8000000000000000; vi[7] = 32'h40;
      vd[8] = 64'd100;              vs[8] = 64'd7;                vi[8] = 32'd13;
      vd[9] = 64'hFEDCBA9876543210; vs[9] = 64'h0123456789ABCDEF; vi[9] = 32'h12345678;

      // R11: reset state, with activity on the inputs
      in_valid = 1'b1; opcode = 8'h07; dst_in = 64'h55;
      repeat (3) @(negedge clk);
      check("R11", {out_valid, illegal, result}, 66'h0);
      in_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R11", {out_valid, illegal, result}, 66'h0);

      // R2: immediate extension per width
      issue("R2", 8'hb7, 64'h0, 64'h1111, 32'h80000005);
      check("R2", {out_valid, illegal, result}, {2'b10, 64'hFFFFFFFF80000005});
      issue("R2", 8'hb4, 64'h0, 64'h1111, 32'h80000005);
      check("R2", {out_valid, illegal, result}, {2'b10, 64'h0000000080000005});
      issue("R2", 8'hbf, 64'h0, 64'hABCD, 32'h80000005);
      check("R2", {out_valid, illegal, result}, {2'b10, 64'hABCD});
      // R3: narrow add wraps, upper bits dropped
      issue("R3", 8'h0c, 64'hAAAAAAAAFFFFFFFF, 64'hBBBBBBBB00000002, 32'h0);
      check("R3", {out_valid, illegal, result}, {2'b10, 64'h1});
      // R8: source has no effect
      issue("R8", 8'h8f, 64'h5, 64'h1234, 32'h0);
      check("R8", {out_valid, illegal, result}, {2'b10, 64'hFFFFFFFFFFFFFFFB});
      idle_gap();

      for (int c = 0; c < 4; c++) begin
         logic [2:0] cls;
         cls = (c == 0) ? 3'h4 : (c == 1) ? 3'h7 : (c == 2) ? 3'h0 : 3'h5;
         for (int sb = 0; sb < 2; sb++) begin
            for (int op = 0; op < 16; op++) begin
               for (int v = 0; v < 10; v++) begin
                  logic [7:0] o8;
                  o8 = {op[3:0], sb[0], cls};
                  issue(tag_of(o8), o8, vd[v], vs[v], vi[v]);
               end
            end
            idle_gap();
         end
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule